// File: doc/BRIEF.md
# Paged Host Configuration Register Window

This block is the host-facing register window of a bus-attached network controller. The host reaches it through a small synchronous strobe interface: a 10-bit I/O address, a read strobe, a write strobe, 8-bit write data and combinational read data. An access counts only when the address falls inside the block's 32-byte I/O window and the DMA address-enable input is low. The low four address bits pick a register offset, and a two-bit page field in the command register picks one of four register pages.

Two configuration registers share their page-0 offsets with the two remote byte-count registers. A write reaches a configuration register only when the access just before it was a read of that same offset. Every other write to those offsets goes to the byte-count register. Configuration register A sets where the I/O window sits. It also selects the one interrupt line, out of eight, that the block drives; the other seven are left undriven. Page 2 adds three registers: a readback of the eight interrupt line levels, a pull-down enable per line, and the boot ROM page address.

Top module: `cfg_regwin`

## Requirements
- R1: After reset the command register reads 0x21, which is page 0. Configuration A, configuration B, both byte counts, the pull-down enables and the boot ROM page are all zero. The unlock is disarmed.
- R2: An access takes effect only when `dma_aen` is 0, `host_addr[9:5]` equals `io_base[9:5]` and `host_addr[4]` is 0. The offset is `host_addr[3:0]`. Any other access changes no state, and a read outside these conditions returns 0.
- R3: Offset 0x0 is the command register on every page, readable and writable. Its bits 7:6 select the register page for all other offsets.
- R4: On page 0 at offset 0xA, a read returns configuration A. A write goes to configuration A only if the qualifying access just before it was a page-0 read of 0xA. Otherwise the write goes to byte count 0, on output `rbc0`.
- R5: On page 0 at offset 0xB, the same rule selects between configuration B and byte count 1 (`rbc1`). Only bits 0, 1 and 4 of configuration B are stored; its other bits read 0.
- R6: Any qualifying access to another offset or page disarms the unlock. So does the unlocked write itself.
- R7: `io_base` equals 0x300 + 0x20 × configuration A bits 2:0. Bit 3 has no effect on it.
- R8: `irq_oe` is one-hot at index configuration A bits 6:4, where indices 0..7 stand for IRQ3, 4, 5, 9, 10, 11, 12, 15. `irq_out` is high on the enabled line exactly while `irq_req` is 1, and low on every other line.
- R9: On page 2, a read of 0x9 returns `irq_line_in`, with the IRQ3 line in bit 0 and the IRQ15 line in bit 7. A write to 0x9 loads `irq_pd_en`.
- R10: Page 2 offset 0xA is the boot ROM page register. It is readable and writable, and it drives `rom_page`.
- R11: All other offsets on every page read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Host I/O address |
| dma_aen | input | 1 | DMA address enable; while high, host accesses are ignored |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational, valid in the strobe cycle |
| irq_req | input | 1 | Pending unmasked interrupt |
| irq_line_in | input | 8 | Sensed levels of the eight interrupt lines |
| irq_oe | output | 8 | Per-line drive enable (tri-state control) |
| irq_out | output | 8 | Per-line driven value |
| irq_pd_en | output | 8 | Per-line pull-down enable |
| rom_page | output | 8 | Boot ROM page address |
| io_base | output | 10 | Current I/O window base |
| rbc0 | output | 8 | Remote byte count, low byte |
| rbc1 | output | 8 | Remote byte count, high byte |
| cfg_b | output | 8 | Configuration B contents |

## Verification
The assertions assume that the host never raises `rd_stb` and `wr_stb` in the same cycle, and one of them checks that rule. They also assume that a change in any stored register follows a qualifying write to that register's offset. The bench builds every access through one task, which raises exactly one strobe. Between accesses it puts idle cycles with no strobe. Accesses that are meant to miss the window use explicit raw addresses. The unlock sequences cover every interleaving the rule separates: read then write, write with no read, an intervening read of another offset, and a page change between the read and the write.

// File: rtl/cfg_regwin_pkg.sv
// Shared constants and types for the paged configuration register window.
// Assumes an 8-bit data path and a 4-bit register offset.
package cfg_regwin_pkg;
    typedef enum logic [1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;

    localparam logic [3:0] OFS_CMD   = 4'h0;
    localparam logic [3:0] OFS_LINES = 4'h9;
    localparam logic [3:0] OFS_CFGA  = 4'hA;
    localparam logic [3:0] OFS_CFGB  = 4'hB;
    localparam logic [3:0] OFS_ROMPG = 4'hA;

    localparam logic [7:0] CMD_RESET = 8'h21;
    localparam logic [7:0] CFGB_KEEP = 8'h13;
endpackage

// File: rtl/cfg_regwin_decode.sv
// Address qualifier: accepts a host access when the address falls in the
// window at base and DMA address enable is low. Assumes that AW > WIN_SH > OFS_W.
module cfg_regwin_decode #(
    parameter int AW     = 10,
    parameter int OFS_W  = 4,
    parameter int WIN_SH = 5
) (
    input  logic [AW-1:0]    addr,
    input  logic             aen,
    input  logic             rd,
    input  logic             wr,
    input  logic [AW-1:0]    base,
    output logic             rd_hit,
    output logic             wr_hit,
    output logic [OFS_W-1:0] ofs
);
    logic in_win;

    // Window compare on the upper address bits; the gap bits must be zero.
    always_comb begin
        in_win = !aen && (addr[AW-1:WIN_SH] == base[AW-1:WIN_SH])
                      && (addr[WIN_SH-1:OFS_W] == '0);
        rd_hit = in_win && rd;
        wr_hit = in_win && wr;
        ofs    = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/cfg_regwin_unlock.sv
// Read-then-write unlock tracker. It arms on a page-0 read of one of the two
// shared offsets and disarms on any other qualifying access.
// Assumes that rd_hit and wr_hit are never high together.
module cfg_regwin_unlock
    import cfg_regwin_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       page,
    output logic             unlock_a,
    output logic             unlock_b
);
    logic armed_q;
    logic armed_b_q;
    logic shared_ofs;

    // Marks the two offsets that a configuration register shares with a byte count.
    always_comb shared_ofs = (ofs == OFS_CFGA) || (ofs == OFS_CFGB);

    // Re-evaluates the armed state on every qualifying access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            armed_b_q <= 1'b0;
        end else if (rd_hit || wr_hit) begin
            armed_q   <= rd_hit && (page == PG0) && shared_ofs;
            armed_b_q <= (ofs == OFS_CFGB);
        end
    end

    assign unlock_a = armed_q && !armed_b_q;
    assign unlock_b = armed_q &&  armed_b_q;

    // R6
    wr_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !(unlock_a || unlock_b));
    // R6
    rd_other_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !shared_ofs) |=> !(unlock_a || unlock_b));
endmodule

// File: rtl/cfg_regwin_irqroute.sv
// Interrupt steering: drives exactly one of NIRQ lines, chosen by sel, and
// leaves the rest undriven. Assumes that NIRQ equals 2**SEL_W.
module cfg_regwin_irqroute #(
    parameter int SEL_W = 3,
    localparam int NIRQ = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             req,
    output logic [NIRQ-1:0]  oe,
    output logic [NIRQ-1:0]  level
);
    // One decoder slice per interrupt line.
    for (genvar k = 0; k < NIRQ; k++) begin : g_line
        always_comb begin
            oe[k]    = (sel == SEL_W'(k));
            level[k] = oe[k] && req;
        end
    end

    // R8
    irq_single_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oe) == 1);
    // R8
    irq_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0) == req);
endmodule

// File: rtl/cfg_regwin.sv
// Paged configuration register window (top). It holds the command register,
// configuration A and B, both remote byte counts, the interrupt pull-down
// enables and the boot ROM page register. Assumes one strobe per cycle at most.
module cfg_regwin
    import cfg_regwin_pkg::*;
#(
    parameter int          AW      = 10,
    parameter int          DW      = 8,
    parameter int          OFS_W   = 4,
    parameter int          WIN_SH  = 5,
    parameter int          SEL_W   = 3,
    parameter logic [9:0]  BASE_LO = 10'h300,
    localparam int         NIRQ    = 1 << SEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   host_addr,
    input  logic            dma_aen,
    input  logic            rd_stb,
    input  logic            wr_stb,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    input  logic            irq_req,
    input  logic [NIRQ-1:0] irq_line_in,
    output logic [NIRQ-1:0] irq_oe,
    output logic [NIRQ-1:0] irq_out,
    output logic [NIRQ-1:0] irq_pd_en,
    output logic [DW-1:0]   rom_page,
    output logic [AW-1:0]   io_base,
    output logic [DW-1:0]   rbc0,
    output logic [DW-1:0]   rbc1,
    output logic [DW-1:0]   cfg_b
);
    logic [DW-1:0]    cmd_q, cfga_q, cfgb_q, rbc0_q, rbc1_q, pd_q, rompg_q;
    logic             rd_hit, wr_hit, unlock_a, unlock_b;
    logic [OFS_W-1:0] ofs;
    logic [1:0]       page;

    assign page = cmd_q[7:6];

    // Places the window at BASE_LO plus one window step per code.
    always_comb io_base = BASE_LO + (AW'(cfga_q[SEL_W-1:0]) << WIN_SH);

    cfg_regwin_decode #(.AW(AW), .OFS_W(OFS_W), .WIN_SH(WIN_SH)) u_decode (
        .addr(host_addr), .aen(dma_aen), .rd(rd_stb), .wr(wr_stb),
        .base(io_base), .rd_hit(rd_hit), .wr_hit(wr_hit), .ofs(ofs));

    cfg_regwin_unlock #(.OFS_W(OFS_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit),
        .ofs(ofs), .page(page), .unlock_a(unlock_a), .unlock_b(unlock_b));

    cfg_regwin_irqroute #(.SEL_W(SEL_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .sel(cfga_q[6:4]), .req(irq_req),
        .oe(irq_oe), .level(irq_out));

    // Register writes, with the page-0 shared offsets steered by the unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_RESET;
            cfga_q  <= '0;
            cfgb_q  <= '0;
            rbc0_q  <= '0;
            rbc1_q  <= '0;
            pd_q    <= '0;
            rompg_q <= '0;
        end else if (wr_hit) begin
            if (ofs == OFS_CMD) begin
                cmd_q <= wr_data;
            end else begin
                case (page)
                    PG0: begin
                        if (ofs == OFS_CFGA) begin
                            if (unlock_a) cfga_q <= wr_data;
                            else          rbc0_q <= wr_data;
                        end else if (ofs == OFS_CFGB) begin
                            if (unlock_b) cfgb_q <= wr_data & CFGB_KEEP;
                            else          rbc1_q <= wr_data;
                        end
                    end
                    PG2: begin
                        if (ofs == OFS_LINES)      pd_q    <= wr_data;
                        else if (ofs == OFS_ROMPG) rompg_q <= wr_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; it returns zero for unmapped offsets and for misses.
    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            if (ofs == OFS_CMD) begin
                rd_data = cmd_q;
            end else if (page == PG0) begin
                if (ofs == OFS_CFGA)      rd_data = cfga_q;
                else if (ofs == OFS_CFGB) rd_data = cfgb_q;
            end else if (page == PG2) begin
                if (ofs == OFS_LINES)      rd_data = irq_line_in;
                else if (ofs == OFS_ROMPG) rd_data = rompg_q;
            end
        end
    end

    assign irq_pd_en = pd_q;
    assign rom_page  = rompg_q;
    assign rbc0      = rbc0_q;
    assign rbc1      = rbc1_q;
    assign cfg_b     = cfgb_q;

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
    // R4
    cfga_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfga_q != $past(cfga_q)) |-> ($past(wr_hit) && $past(ofs) == OFS_CFGA));
    // R4
    cfga_rbc0_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((cfga_q != $past(cfga_q)) && (rbc0_q != $past(rbc0_q))));
    // R5
    cfgb_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfgb_q & ~CFGB_KEEP) == '0);
    // R10
    rompg_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rompg_q != $past(rompg_q)) |-> ($past(wr_hit) && $past(page) == PG2));
endmodule

// File: tb/cfg_regwin_tb.sv
module cfg_regwin_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       dma_aen = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, irq_req = 1'b0;
    logic [7:0] wr_data = '0, irq_line_in = '0;
    logic [7:0] rd_data, irq_oe, irq_out, irq_pd_en, rom_page, rbc0, rbc1, cfg_b;
    logic [9:0] io_base;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Behavioural reference state
    int m_cmd, m_cra, m_crb, m_rbc0, m_rbc1, m_pd, m_rom;
    int m_arm;   // -1 when disarmed, otherwise the armed offset

    always #4 clk = ~clk;

    cfg_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .dma_aen(dma_aen),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .irq_req(irq_req), .irq_line_in(irq_line_in), .irq_oe(irq_oe),
        .irq_out(irq_out), .irq_pd_en(irq_pd_en), .rom_page(rom_page),
        .io_base(io_base), .rbc0(rbc0), .rbc1(rbc1), .cfg_b(cfg_b));

    function automatic int m_base();
        return 'h300 + 32 * (m_cra & 7);
    endfunction

    function automatic bit m_hit();
        return !dma_aen && (int'(host_addr) >= m_base()) && (int'(host_addr) < m_base() + 16);
    endfunction

    function automatic int m_read();
        int o, pg;
        if (!rd_stb || !m_hit()) return 0;
        o  = int'(host_addr) - m_base();
        pg = (m_cmd >> 6) & 3;
        if (o == 0) return m_cmd;
        if (pg == 0 && o == 10) return m_cra;
        if (pg == 0 && o == 11) return m_crb;
        if (pg == 2 && o == 9)  return int'(irq_line_in);
        if (pg == 2 && o == 10) return m_rom;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compares every output against the model; called once per cycle
    task automatic compare_all();
        int sel;
        sel = (m_cra >> 4) & 7;
        chk("R2/R3/R4/R9/R11 rd_data", int'(rd_data), m_read());
        chk("R7 io_base", int'(io_base), m_base());
        chk("R8 irq_oe", int'(irq_oe), 1 << sel);
        chk("R8 irq_out", int'(irq_out), irq_req ? (1 << sel) : 0);
        chk("R9 irq_pd_en", int'(irq_pd_en), m_pd);
        chk("R10 rom_page", int'(rom_page), m_rom);
        chk("R4 rbc0", int'(rbc0), m_rbc0);
        chk("R5 rbc1", int'(rbc1), m_rbc1);
        chk("R5 cfg_b", int'(cfg_b), m_crb);
    endtask

    // Reference update at the clock edge
    task automatic model_edge();
        int o, pg, d;
        if (!rst_n) begin
            m_cmd = 'h21; m_cra = 0; m_crb = 0; m_rbc0 = 0; m_rbc1 = 0;
            m_pd = 0; m_rom = 0; m_arm = -1;
            return;
        end
        if (!m_hit() || !(rd_stb || wr_stb)) return;
        o  = int'(host_addr) - m_base();
        pg = (m_cmd >> 6) & 3;
        d  = int'(wr_data);
        if (wr_stb) begin
            if (o == 0) m_cmd = d;
            else if (pg == 0 && o == 10) begin
                if (m_arm == 10) m_cra = d; else m_rbc0 = d;
            end else if (pg == 0 && o == 11) begin
                if (m_arm == 11) m_crb = d & 'h13; else m_rbc1 = d;
            end else if (pg == 2 && o == 9) m_pd = d;
            else if (pg == 2 && o == 10) m_rom = d;
            m_arm = -1;
        end else begin
            m_arm = (pg == 0 && (o == 10 || o == 11)) ? o : -1;
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model at the rising edge
    task automatic cyc(bit rd, bit wr, logic [9:0] a, logic [7:0] d, bit aen);
        @(negedge clk);
        rd_stb = rd; wr_stb = wr; host_addr = a; wr_data = d; dma_aen = aen;
        #1 compare_all();
        @(posedge clk);
        model_edge();
    endtask

    task automatic rd_ofs(int o);
        cyc(1, 0, 10'(m_base() + o), 8'h00, 0);
        cyc(0, 0, 10'(m_base() + o), 8'h00, 0);
    endtask

    task automatic wr_ofs(int o, int d);
        cyc(0, 1, 10'(m_base() + o), 8'(d), 0);
        cyc(0, 0, 10'(m_base() + o), 8'h00, 0);
    endtask

    task automatic set_page(int p);
        wr_ofs(0, (p << 6) | 'h21);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(0, 0, 10'h300, 8'h00, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk);
        rd_ofs(0); rd_ofs(10); rd_ofs(11);
        // R4: write without a prior read goes to byte count 0
        wr_ofs(10, 'h5A);
        // R4: read then write goes to configuration A (base 0x3A0, IRQ5, bit 3 set)
        rd_ofs(10); wr_ofs(10, 'h2D);
        irq_req = 1'b1; rd_ofs(0);
        // R5: the same rule for configuration B and byte count 1
        wr_ofs(11, 'hC3);
        rd_ofs(11); wr_ofs(11, 'hFF); rd_ofs(11);
        // R6: a read of another offset disarms
        rd_ofs(10); rd_ofs(3); wr_ofs(10, 'h77);
        // R6: a read of 0xB arms only 0xB
        rd_ofs(11); wr_ofs(10, 'h66);
        // R6: a page change between the read and the write
        rd_ofs(10); set_page(2); wr_ofs(10, 'hA5); rd_ofs(10);
        // R9: line status readback and pull-down enable
        irq_line_in = 8'h96; rd_ofs(9); wr_ofs(9, 'h3C);
        // R11: unmapped offsets on pages 1 and 3
        set_page(1); rd_ofs(10); wr_ofs(5, 'hEE); rd_ofs(5);
        set_page(3); rd_ofs(9); wr_ofs(11, 'h11);
        set_page(0); rd_ofs(10); wr_ofs(10, 'h44);
        // R2: accesses that miss the window or come with the DMA enable high
        cyc(0, 1, 10'(m_base() + 11), 8'h99, 1);
        cyc(1, 0, 10'(m_base() + 10), 8'h00, 1);
        cyc(0, 1, 10'(m_base() + 16 + 11), 8'h98, 0);
        cyc(1, 0, 10'(m_base() + 16 + 10), 8'h00, 0);
        cyc(0, 1, 10'h300 + 11, 8'h97, 0);
        rd_ofs(11);
        // R7/R8: sweep every code; the window moves after each write
        for (int c = 0; c < 8; c++) begin
            rd_ofs(10); wr_ofs(10, (c << 4) | ((7 - c) & 7) | ((c & 1) << 3));
            irq_req = c[0]; cyc(0, 0, 10'h000, 8'h00, 0);
        end
        irq_req = 1'b0;
        rd_ofs(0); rd_ofs(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule